// File: doc/BRIEF.md
# Debug-Port Clock Measurement Counter

This block is a data register on the test access port that lets an external debugger estimate how fast the chip's system clock runs. The debugger selects the block with its instruction code. It then shifts a 16-bit count in through the scan chain and commits it with Update-DR. The count is handed across to the system clock domain. There it decrements once per system clock cycle, and the block reports busy for exactly as many cycles as the count holds.

The debugger times the interval from the commit until busy reads back as zero. It reads busy with short, repeated status scans. Dividing the count by the measured wall time gives the system clock rate. A commit that arrives while a measurement is still running is rejected and raises an error flag. A scan that stops early only reads status and never starts a count.

The test access port controller is outside the block. It supplies the current instruction and one-cycle decodes of the Capture-IR, Capture-DR, Shift-DR and Update-DR states.

Top module: `clkmeas_dr`

## Requirements
- R1: The register responds only while the instruction input equals 5'h17. With any other instruction, scans and updates start no count.
- R2: An update after at least 16 bits have been shifted starts a count. The system-side busy output is then high for exactly N system clock cycles, where N is the 16-bit value held in the register.
- R3: An update after fewer than 16 shifted bits is ignored. It starts no count and leaves the error flag clear.
- R4: On Capture-DR the register loads status with busy at bit 0 and error at bit 1. It shifts LSB-first: tdo shows bit 0 and tdi enters at bit 15.
- R5: A full update while a measurement is in progress is ignored and sets the error flag. The running count finishes with its original length.
- R6: A Capture-IR pulse clears the error flag.
- R7: The instruction capture value is {protect, error, busy, 1'b0, 1'b1}, from bit 4 down to bit 0.
- R8: Busy as seen by the debugger is high from the commit until the system-side count has finished, and then reads zero.
- R9: A committed count of zero produces no system-side busy cycle, and the debugger's busy flag returns to zero.
- R10: After reset, tdo is 0 and both the error and busy flags are 0.
- R11: When more than 16 bits are shifted, the last 16 bits shifted in form the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| tck_rst_n | input | 1 | Active-low reset, scan domain |
| ir_value | input | 5 | Current instruction from the TAP controller |
| capture_ir | input | 1 | Capture-IR state decode |
| capture_dr | input | 1 | Capture-DR state decode |
| shift_dr | input | 1 | Shift-DR state decode |
| update_dr | input | 1 | Update-DR state decode |
| tdi | input | 1 | Serial data in |
| prot_flag | input | 1 | Protection status reported in the instruction capture |
| tdo | output | 1 | Serial data out |
| ir_capture | output | 5 | Value loaded into the instruction register on Capture-IR |
| sys_clk | input | 1 | System clock being measured |
| sys_rst_n | input | 1 | Active-low reset, system domain |
| sys_busy | output | 1 | High while the system-side count runs |

## Verification
The hardest state to reach is a second full-length commit that lands while a count is still crossing or running. The stimulus commits a long count and issues a full 16-bit scan with update straight away. It then checks three things: the error bit in the next status scan and in the instruction capture, and that the system-side busy time still matches the first count. Counts of zero, truncated scans, over-length scans and a foreign instruction each get their own directed run after the table of counts.

// File: rtl/clkmeas_pkg.sv
package clkmeas_pkg;
   localparam int unsigned IR_W       = 5;
   localparam logic [4:0]  IR_CLKMEAS = 5'h17;
   localparam int unsigned DR_W       = 16;
   localparam int unsigned SYNC_DEPTH = 2;
   localparam int unsigned ST_BUSY    = 0;
   localparam int unsigned ST_ERR     = 1;
endpackage

// File: rtl/clkmeas_sync.sv
module clkmeas_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   initial assert (STAGES >= 2) else $error("sync depth below two");

   generate
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[0], d};
         end
      end else begin : g_deep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/clkmeas_scan.sv
module clkmeas_scan #(
   parameter int unsigned DR_W            = 16,
   parameter int unsigned IR_W            = 5,
   parameter logic [IR_W-1:0] IR_CODE     = 5'h17,
   parameter bit          TRUNC_FLAGS_ERR = 1'b0
) (
   input  logic            tck,
   input  logic            rst_n,
   input  logic [IR_W-1:0] ir_value,
   input  logic            capture_ir,
   input  logic            capture_dr,
   input  logic            shift_dr,
   input  logic            update_dr,
   input  logic            tdi,
   input  logic            prot_flag,
   input  logic            done_sync,
   output logic            tdo,
   output logic [IR_W-1:0] ir_capture,
   output logic            req_tgl,
   output logic [DR_W-1:0] load_val
);
   localparam int unsigned CNT_W = $clog2(DR_W + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DR_W);

   logic [DR_W-1:0]  shreg;
   logic [DR_W-1:0]  status;
   logic [CNT_W-1:0] shift_cnt;
   logic             err;
   logic             sel, full, busy_tck;
   logic             start_ok, reject, trunc_err;

   initial assert (DR_W >= 2) else $error("data register too narrow");
   initial assert (IR_W == 5) else $error("capture layout needs five bits");

   assign sel      = (ir_value == IR_CODE);
   assign full     = (shift_cnt == FULL_CNT);
   assign busy_tck = req_tgl ^ done_sync;
   assign start_ok = update_dr & sel & full & ~busy_tck;
   assign reject   = update_dr & sel & full &  busy_tck;

   generate
      if (TRUNC_FLAGS_ERR) begin : g_trunc_err
         assign trunc_err = update_dr & sel & ~full;
      end else begin : g_trunc_ignore
         assign trunc_err = 1'b0;
      end
   endgenerate

   always_comb begin
      status          = '0;
      status[clkmeas_pkg::ST_BUSY] = busy_tck;
      status[clkmeas_pkg::ST_ERR]  = err;
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         shift_cnt <= '0;
      end else if (capture_dr && sel) begin
         shreg     <= status;
         shift_cnt <= '0;
      end else if (shift_dr && sel) begin
         shreg     <= {tdi, shreg[DR_W-1:1]};
         if (!full) shift_cnt <= shift_cnt + 1'b1;
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         req_tgl  <= 1'b0;
         load_val <= '0;
      end else if (start_ok) begin
         req_tgl  <= ~req_tgl;
         load_val <= shreg;
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)                err <= 1'b0;
      else if (capture_ir)       err <= 1'b0;
      else if (reject || trunc_err) err <= 1'b1;
   end

   assign tdo        = shreg[0];
   assign ir_capture = {prot_flag, err, busy_tck, 2'b01};

   AST_TRUNC_NO_START: assert property (@(posedge tck) disable iff (!rst_n)
      (update_dr && sel && !full) |=> (req_tgl == $past(req_tgl))); // R3
   AST_REJECT_WHILE_BUSY: assert property (@(posedge tck) disable iff (!rst_n)
      (update_dr && sel && full && busy_tck && !capture_ir) |=> (err && req_tgl == $past(req_tgl))); // R5
   AST_ERR_CLEAR: assert property (@(posedge tck) disable iff (!rst_n)
      capture_ir |=> !err); // R6
   AST_FOREIGN_IR: assert property (@(posedge tck) disable iff (!rst_n)
      !sel |=> $stable(req_tgl)); // R1
endmodule

// File: rtl/clkmeas_count.sv
module clkmeas_count #(
   parameter int unsigned DR_W        = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_tgl,
   input  logic [DR_W-1:0] load_val,
   output logic            busy,
   output logic            done_tgl
);
   logic            req_s, req_d, start;
   logic [DR_W-1:0] cnt;

   clkmeas_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(req_tgl), .q(req_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_d <= 1'b0;
      else        req_d <= req_s;
   end

   assign start = req_s ^ req_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         busy     <= 1'b0;
         done_tgl <= 1'b0;
      end else if (start) begin
         cnt  <= load_val;
         busy <= |load_val;
         if (load_val == '0) done_tgl <= ~done_tgl;
      end else if (busy) begin
         cnt <= cnt - 1'b1;
         if (cnt == DR_W'(1)) begin
            busy     <= 1'b0;
            done_tgl <= ~done_tgl;
         end
      end
   end

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start) |=> (cnt == $past(cnt) - DR_W'(1))); // R2
   AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy); // R5
   AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done_tgl != $past(done_tgl))); // R8
endmodule

// File: rtl/clkmeas_dr.sv
module clkmeas_dr #(
   parameter int unsigned DR_W            = clkmeas_pkg::DR_W,
   parameter int unsigned IR_W            = clkmeas_pkg::IR_W,
   parameter logic [IR_W-1:0] IR_CODE     = clkmeas_pkg::IR_CLKMEAS,
   parameter int unsigned SYNC_STAGES     = clkmeas_pkg::SYNC_DEPTH,
   parameter bit          TRUNC_FLAGS_ERR = 1'b0
) (
   input  logic            tck,
   input  logic            tck_rst_n,
   input  logic [IR_W-1:0] ir_value,
   input  logic            capture_ir,
   input  logic            capture_dr,
   input  logic            shift_dr,
   input  logic            update_dr,
   input  logic            tdi,
   input  logic            prot_flag,
   output logic            tdo,
   output logic [IR_W-1:0] ir_capture,
   input  logic            sys_clk,
   input  logic            sys_rst_n,
   output logic            sys_busy
);
   logic            req_tgl, done_tgl, done_sync;
   logic [DR_W-1:0] load_val;

   clkmeas_scan #(
      .DR_W(DR_W), .IR_W(IR_W), .IR_CODE(IR_CODE), .TRUNC_FLAGS_ERR(TRUNC_FLAGS_ERR)
   ) u_scan (
      .tck(tck), .rst_n(tck_rst_n), .ir_value(ir_value),
      .capture_ir(capture_ir), .capture_dr(capture_dr), .shift_dr(shift_dr),
      .update_dr(update_dr), .tdi(tdi), .prot_flag(prot_flag),
      .done_sync(done_sync), .tdo(tdo), .ir_capture(ir_capture),
      .req_tgl(req_tgl), .load_val(load_val)
   );

   clkmeas_count #(.DR_W(DR_W), .SYNC_STAGES(SYNC_STAGES)) u_count (
      .clk(sys_clk), .rst_n(sys_rst_n), .req_tgl(req_tgl),
      .load_val(load_val), .busy(sys_busy), .done_tgl(done_tgl)
   );

   clkmeas_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
      .clk(tck), .rst_n(tck_rst_n), .d(done_tgl), .q(done_sync)
   );
endmodule

// File: tb/clkmeas_dr_tb_top.sv
module clkmeas_dr_tb_top;
   logic       tck = 1'b0, sys_clk = 1'b0;
   logic       tck_rst_n = 1'b0, sys_rst_n = 1'b0;
   logic [4:0] ir_value = 5'h17;
   logic       capture_ir = 0, capture_dr = 0, shift_dr = 0, update_dr = 0;
   logic       tdi = 0, prot_flag = 0;
   logic       tdo, sys_busy;
   logic [4:0] ir_capture;

   int errors = 0, checks = 0, busy_total = 0;

   always #10 sys_clk = ~sys_clk;
   always #50 tck = ~tck;
   always @(negedge sys_clk) if (sys_busy) busy_total++;

   clkmeas_dr dut_i (
      .tck(tck), .tck_rst_n(tck_rst_n), .ir_value(ir_value),
      .capture_ir(capture_ir), .capture_dr(capture_dr), .shift_dr(shift_dr),
      .update_dr(update_dr), .tdi(tdi), .prot_flag(prot_flag), .tdo(tdo),
      .ir_capture(ir_capture), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
      .sys_busy(sys_busy)
   );

   // each entry: {expected busy cycles, committed count}
   localparam logic [31:0] VEC [5] = '{
      {16'd1, 16'd1}, {16'd5, 16'd5}, {16'd37, 16'd37},
      {16'd200, 16'd200}, {16'd1023, 16'd1023}};

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic scan_dr(input logic [31:0] val, input int nbits, input bit upd,
                          output logic [31:0] got);
      got = '0;
      @(negedge tck); capture_dr = 1;
      @(negedge tck); capture_dr = 0; shift_dr = 1;
      for (int i = 0; i < nbits; i++) begin
         tdi = val[i];
         got[i] = tdo;
         @(negedge tck);
      end
      shift_dr = 0;
      if (upd) begin
         update_dr = 1;
         @(negedge tck); update_dr = 0;
      end
   endtask

   task automatic poll(output int polls, output bit first_busy);
      logic [31:0] g;
      polls = 0;
      first_busy = 0;
      for (int k = 0; k < 3000; k++) begin
         scan_dr(32'h0, 2, 1'b1, g);
         if (k == 0) first_busy = g[0];
         polls++;
         if (!g[0]) break;
      end
   endtask

   task automatic pulse_capture_ir();
      @(negedge tck); capture_ir = 1;
      @(negedge tck); capture_ir = 0;
   endtask

   initial begin : watchdog
      #2_000_000;
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      logic [31:0] got;
      int polls, base;
      bit fb;
      repeat (3) @(negedge tck);
      tck_rst_n = 1; sys_rst_n = 1;
      @(negedge tck);
      // R10 reset state
      check(tdo == 1'b0, "R10 tdo", tdo, 0);
      check(ir_capture == 5'b00001, "R10 ir_capture", ir_capture, 1);
      prot_flag = 1; #1;
      check(ir_capture == 5'b10001, "R7 protect bit", ir_capture, 17);
      prot_flag = 0;

      // table of counts: R2 busy length, R8 polling
      for (int v = 0; v < 5; v++) begin
         base = busy_total;
         scan_dr({16'h0, VEC[v][15:0]}, 16, 1'b1, got);
         poll(polls, fb);
         check(polls < 3000, "R8 poll ends", polls, 0);
         check(busy_total - base == int'(VEC[v][31:16]), "R2 busy cycles",
               busy_total - base, int'(VEC[v][31:16]));
         if (VEC[v][15:0] >= 16'd37) check(fb == 1'b1, "R8 first poll busy", fb, 1);
      end

      // R9 zero count
      base = busy_total;
      scan_dr(32'h0, 16, 1'b1, got);
      poll(polls, fb);
      check(polls < 3000, "R9 busy clears", polls, 0);
      check(busy_total == base, "R9 no busy", busy_total - base, 0);

      // R3 truncated scan
      base = busy_total;
      scan_dr(32'h0100, 8, 1'b1, got);
      repeat (20) @(negedge tck);
      check(busy_total == base, "R3 no start", busy_total - base, 0);
      check(ir_capture[3] == 1'b0, "R3 no error", ir_capture[3], 0);

      // R1 foreign instruction
      ir_value = 5'h0C;
      base = busy_total;
      scan_dr(32'h0010, 16, 1'b1, got);
      repeat (20) @(negedge tck);
      check(busy_total == base, "R1 ignored", busy_total - base, 0);
      ir_value = 5'h17;

      // R11 over-length scan: bits [19:4] of the stream become 64
      base = busy_total;
      scan_dr(32'h0040F, 20, 1'b1, got);
      poll(polls, fb);
      check(busy_total - base == 64, "R11 last sixteen", busy_total - base, 64);

      // R5 commit while busy, R4 status layout, R7, R6
      base = busy_total;
      scan_dr(32'd300, 16, 1'b1, got);
      repeat (3) @(negedge tck);
      scan_dr(32'd5, 16, 1'b1, got);
      scan_dr(32'h0, 4, 1'b0, got);
      check(got[1:0] == 2'b11, "R4 status busy+err", got[1:0], 3);
      check(got[3:2] == 2'b00, "R4 upper bits", got[3:2], 0);
      check(ir_capture == 5'b01101, "R7 capture busy+err", ir_capture, 13);
      poll(polls, fb);
      check(busy_total - base == 300, "R5 original count", busy_total - base, 300);
      check(ir_capture[3] == 1'b1, "R5 error held", ir_capture[3], 1);
      pulse_capture_ir();
      check(ir_capture[3] == 1'b0, "R6 error cleared", ir_capture[3], 0);
      scan_dr(32'h0, 2, 1'b0, got);
      check(got[1] == 1'b0, "R6 status error", got[1], 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule